// File: doc/BRIEF.md
# Byte-Wide Static Memory with Single-Error Correction

This block is a synthesizable byte-wide static memory whose words are protected by a single-error-correcting code. Software-facing logic drives it the way it would drive a discrete asynchronous memory: active-low select, output-drive and store strobes, an address, and a byte of data. The bidirectional data bus is split into an input byte, an output byte and a drive-enable. An error flag is split the same way, into a value and its own drive-enable. All strobes are sampled on the block clock.

Each stored byte is widened into a 13-bit codeword. Bit 0 of the codeword is an overall parity bit. Positions 1, 2, 4 and 8 hold Hamming check bits. Data bits 0 to 7 sit at positions 3, 5, 6, 7, 9, 10, 11 and 12, in that order. On every read the codeword is checked and any single flipped bit is repaired on its way to the bus, and the flag reports that a repair took place. The repaired value is never put back into storage. A test-only input can invert one chosen codeword bit at one chosen address, so that correction can be exercised.

Top module: `esr_byte_mem`

## Requirements
- R1: With `sel_n` high, `rd_oe` and `flag_oe` are 0 whatever `drv_n` and `st_n` do, no store takes place, and `rd_data`/`flag` read 0 while undriven.
- R2: With `sel_n` low, `drv_n` low and `st_n` high, `rd_oe` and `flag_oe` are 1 and `rd_data` shows the byte stored at `addr` in the same cycle.
- R3: With `sel_n` and `st_n` both low, the cycle is a store of all 8 bits whatever `drv_n` is, and `rd_oe` and `flag_oe` stay 0.
- R4: With `sel_n` low and both `drv_n` and `st_n` high, the block is selected but `rd_oe` and `flag_oe` are 0.
- R5: A store lasts while `sel_n` and `st_n` are both low at a clock edge. It ends when either strobe rises. The address and byte sampled at the last edge with both strobes low are what is kept, and the new content is readable from the cycle after the ending edge.
- R6: When the stored codeword differs from a valid one in exactly one of its 13 bits, a read returns the original byte and drives `flag` to 1.
- R7: A read of a codeword with no error drives `flag` to 0.
- R8: A corrected read leaves storage unchanged. The same address keeps flagging 1 until it is stored again, and a fresh store makes it read clean.
- R9: When two codeword bits are flipped, a read returns the data bits exactly as stored, without correction, and `flag` is 0.
- R10: Reset clears every word to the all-zero codeword, which reads as byte 0x00 with `flag` 0.
- R11: A clock edge with `tst_flip` high inverts codeword bit `tst_pos` (0 to 12) of word `tst_addr`. Values of `tst_pos` from 13 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all strobes sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low select |
| drv_n | input | 1 | Active-low output drive request |
| st_n | input | 1 | Active-low store strobe |
| addr | input | ADDR_W | Word address |
| wr_data | input | 8 | Byte presented for a store |
| rd_data | output | 8 | Byte returned by a read, 0 when undriven |
| rd_oe | output | 1 | Drive enable for the data bus |
| flag | output | 1 | Single-error-corrected indication during a read |
| flag_oe | output | 1 | Drive enable for the flag |
| tst_flip | input | 1 | Test: invert one stored codeword bit at the next edge |
| tst_addr | input | ADDR_W | Test: word to corrupt |
| tst_pos | input | 4 | Test: codeword bit position to invert |

## Verification
Clean reads use all-zero, all-one, alternating and walking-one bytes. These show whether data bits are placed in and taken from the right codeword positions, and whether check bits are formed over the right sets. A single-bit flip is swept over all 13 codeword positions. This separates a data-bit repair from a check-bit or parity-bit repair, and each must raise the flag with the byte intact. Repeating the read after a repair, and then storing again, separates a repair that is only seen on the bus from one written into storage. Double flips and stores ended by either strobe, with data changing mid-store, show whether the decoder refuses to miscorrect and whether the kept byte is the one sampled at the last active edge.

// File: rtl/esr_pkg.sv
package esr_pkg;

    localparam int DATA_W = 8;
    localparam int CHK_W  = 4;
    localparam int CW_W   = DATA_W + CHK_W + 1;
    localparam int POS_W  = 4;

    typedef logic [CW_W-1:0]   codeword_t;
    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [POS_W-1:0]  pos_t;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_READ  = 2'd1,
        BUS_STORE = 2'd2,
        BUS_QUIET = 2'd3
    } bus_mode_e;

    typedef struct packed {
        byte_t data;
        logic  fixed;
        logic  multi;
    } dec_res_t;

    function automatic logic is_pow2(input int p);
        return (p > 0) && ((p & (p - 1)) == 0);
    endfunction

    // Place data bits at the non-power-of-two positions, then fill check bits.
    function automatic codeword_t cw_encode(input byte_t d);
        codeword_t cw;
        int        k;
        logic      x;
        cw = '0;
        k  = 0;
        for (int p = 1; p < CW_W; p++) begin
            if (!is_pow2(p)) begin
                cw[p] = d[k];
                k++;
            end
        end
        for (int c = 0; c < CHK_W; c++) begin
            x = 1'b0;
            for (int p = 1; p < CW_W; p++) begin
                if (((p >> c) & 1) == 1 && p != (1 << c)) x = x ^ cw[p];
            end
            cw[1 << c] = x;
        end
        cw[0] = ^cw[CW_W-1:1];
        return cw;
    endfunction

    function automatic pos_t cw_syndrome(input codeword_t cw);
        pos_t s;
        s = '0;
        for (int p = 1; p < CW_W; p++) begin
            if (cw[p]) s = s ^ POS_W'(p);
        end
        return s;
    endfunction

    function automatic byte_t cw_extract(input codeword_t cw);
        byte_t d;
        int    k;
        d = '0;
        k = 0;
        for (int p = 1; p < CW_W; p++) begin
            if (!is_pow2(p)) begin
                d[k] = cw[p];
                k++;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/esr_ctrl.sv
module esr_ctrl
    import esr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              drv_n,
    input  logic              st_n,
    input  logic [ADDR_W-1:0] addr,
    input  byte_t             wr_data,
    output bus_mode_e         mode,
    output logic              commit,
    output logic [ADDR_W-1:0] commit_addr,
    output byte_t             commit_data
);

    logic              storing;
    logic              storing_q;
    logic [ADDR_W-1:0] hold_addr_q;
    byte_t             hold_data_q;

    always_comb begin
        if (sel_n)       mode = BUS_IDLE;
        else if (!st_n)  mode = BUS_STORE;
        else if (!drv_n) mode = BUS_READ;
        else             mode = BUS_QUIET;
    end

    assign storing = (mode == BUS_STORE);

    always_ff @(posedge clk) begin
        if (rst) begin
            storing_q   <= 1'b0;
            hold_addr_q <= '0;
            hold_data_q <= '0;
        end else begin
            storing_q <= storing;
            if (storing) begin
                hold_addr_q <= addr;
                hold_data_q <= wr_data;
            end
        end
    end

    // The store lands on the edge that first sees either strobe released.
    assign commit      = storing_q && !storing;
    assign commit_addr = hold_addr_q;
    assign commit_data = hold_data_q;

endmodule

// File: rtl/esr_array.sv
module esr_array
    import esr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  codeword_t         wr_cw,
    input  logic              flip_en,
    input  logic [ADDR_W-1:0] flip_addr,
    input  pos_t              flip_pos,
    input  logic [ADDR_W-1:0] rd_addr,
    output codeword_t         rd_cw
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0][CW_W-1:0] words;
    codeword_t                  flip_mask;

    assign flip_mask = (int'(flip_pos) < CW_W) ? (codeword_t'(1) << flip_pos) : '0;

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        codeword_t word_q;
        codeword_t word_nxt;

        always_comb begin
            word_nxt = word_q;
            if (wr_en && wr_addr == ADDR_W'(i))     word_nxt = wr_cw;
            if (flip_en && flip_addr == ADDR_W'(i)) word_nxt = word_nxt ^ flip_mask;
        end

        always_ff @(posedge clk) begin
            if (rst) word_q <= '0;
            else     word_q <= word_nxt;
        end

        assign words[i] = word_q;
    end

    assign rd_cw = words[rd_addr];

endmodule

// File: rtl/esr_decoder.sv
module esr_decoder
    import esr_pkg::*;
(
    input  codeword_t cw,
    output dec_res_t  res
);

    pos_t      syn;
    logic      par;
    codeword_t repaired;

    assign syn = cw_syndrome(cw);
    assign par = ^cw;

    always_comb begin
        repaired  = cw;
        res.fixed = 1'b0;
        res.multi = 1'b0;
        if (par) begin
            if (int'(syn) < CW_W) begin
                repaired  = cw ^ (codeword_t'(1) << syn);
                res.fixed = 1'b1;
            end else begin
                res.multi = 1'b1;
            end
        end else if (syn != '0) begin
            res.multi = 1'b1;
        end
        res.data = cw_extract(res.multi ? cw : repaired);
    end

endmodule

// File: rtl/esr_byte_mem.sv
module esr_byte_mem
    import esr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              drv_n,
    input  logic              st_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    output logic              rd_oe,
    output logic              flag,
    output logic              flag_oe,
    input  logic              tst_flip,
    input  logic [ADDR_W-1:0] tst_addr,
    input  logic [3:0]        tst_pos
);

    bus_mode_e         mode;
    logic              wr_commit;
    logic [ADDR_W-1:0] commit_addr;
    byte_t             commit_data;
    codeword_t         stored_cw;
    dec_res_t          dec;

    esr_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .sel_n       (sel_n),
        .drv_n       (drv_n),
        .st_n        (st_n),
        .addr        (addr),
        .wr_data     (wr_data),
        .mode        (mode),
        .commit      (wr_commit),
        .commit_addr (commit_addr),
        .commit_data (commit_data)
    );

    esr_array #(.ADDR_W(ADDR_W)) array_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_commit),
        .wr_addr   (commit_addr),
        .wr_cw     (cw_encode(commit_data)),
        .flip_en   (tst_flip),
        .flip_addr (tst_addr),
        .flip_pos  (tst_pos),
        .rd_addr   (addr),
        .rd_cw     (stored_cw)
    );

    esr_decoder dec_i (
        .cw  (stored_cw),
        .res (dec)
    );

    assign rd_oe   = (mode == BUS_READ);
    assign flag_oe = (mode == BUS_READ);
    assign rd_data = rd_oe ? dec.data : '0;
    assign flag    = flag_oe && dec.fixed;

endmodule

// File: rtl/esr_checker.sv
module esr_checker #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              sel_n,
    input logic              drv_n,
    input logic              st_n,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        rd_data,
    input logic              rd_oe,
    input logic              flag,
    input logic              flag_oe,
    input logic              tst_flip,
    input logic              wr_commit
);

    p_deselect_hiz_r1: assert property (@(posedge clk) disable iff (rst)
        sel_n |-> (!rd_oe && !flag_oe && rd_data == 8'h00 && !flag));

    p_read_drives_r2: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && !drv_n && st_n) |-> (rd_oe && flag_oe));

    p_store_no_drive_r3: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && !st_n) |-> (!rd_oe && !flag_oe));

    p_quiet_hiz_r4: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && drv_n && st_n) |-> (!rd_oe && !flag_oe));

    p_commit_after_store_r5: assert property (@(posedge clk) disable iff (rst)
        wr_commit |-> (sel_n || st_n));

    // R8: repeated reads of one address with no store or flip change nothing.
    p_read_holds_r8: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && !drv_n && st_n && !tst_flip && !wr_commit)
        |=> (!(!sel_n && !drv_n && st_n && $stable(addr))
             || ($stable(rd_data) && $stable(flag))));

endmodule

bind esr_byte_mem esr_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .sel_n     (sel_n),
    .drv_n     (drv_n),
    .st_n      (st_n),
    .addr      (addr),
    .rd_data   (rd_data),
    .rd_oe     (rd_oe),
    .flag      (flag),
    .flag_oe   (flag_oe),
    .tst_flip  (tst_flip),
    .wr_commit (wr_commit)
);

// File: tb/esr_byte_mem_tb_top.sv
module esr_byte_mem_tb_top;

    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sel_n = 1'b1;
    logic          drv_n = 1'b1;
    logic          st_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wr_data = '0;
    logic [7:0]    rd_data;
    logic          rd_oe;
    logic          flag;
    logic          flag_oe;
    logic          tst_flip = 1'b0;
    logic [AW-1:0] tst_addr = '0;
    logic [3:0]    tst_pos = '0;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    esr_byte_mem #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .sel_n(sel_n), .drv_n(drv_n), .st_n(st_n),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .rd_oe(rd_oe),
        .flag(flag), .flag_oe(flag_oe), .tst_flip(tst_flip),
        .tst_addr(tst_addr), .tst_pos(tst_pos)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic store(input logic [AW-1:0] a, input logic [7:0] d,
                         input bit end_by_sel, input bit drv_lvl);
        @(negedge clk);
        addr = a; wr_data = d; drv_n = drv_lvl; sel_n = 1'b0; st_n = 1'b0;
        @(negedge clk);
        if (end_by_sel) sel_n = 1'b1; else st_n = 1'b1;
        @(negedge clk);
        sel_n = 1'b1; st_n = 1'b1; drv_n = 1'b1;
    endtask

    task automatic read_expect(input logic [AW-1:0] a, input logic [7:0] exp_d,
                               input bit exp_f, input string req);
        @(negedge clk);
        addr = a; sel_n = 1'b0; drv_n = 1'b0; st_n = 1'b1;
        #1;
        check(rd_oe && flag_oe, {req, " drive"}, {rd_oe, flag_oe}, 2'b11);
        check(rd_data == exp_d, {req, " data"}, rd_data, exp_d);
        check(flag == exp_f, {req, " flag"}, flag, exp_f);
        sel_n = 1'b1; drv_n = 1'b1;
    endtask

    task automatic flip(input logic [AW-1:0] a, input int pos);
        @(negedge clk);
        tst_flip = 1'b1; tst_addr = a; tst_pos = 4'(pos);
        @(negedge clk);
        tst_flip = 1'b0;
    endtask

    function automatic int data_bit_pos(input int k);
        int map [8] = '{3, 5, 6, 7, 9, 10, 11, 12};
        return map[k];
    endfunction

    task automatic t_reset();
        @(negedge clk);
        check(!rd_oe && !flag_oe, "R1 idle after reset", {rd_oe, flag_oe}, 0);
        read_expect('0, 8'h00, 1'b0, "R10 word 0");
        read_expect(AW'((1 << AW) - 1), 8'h00, 1'b0, "R10 last word");
    endtask

    task automatic t_modes();
        store(6'd5, 8'h3C, 1'b0, 1'b1);
        // R1: deselected with both other strobes low: no drive, no store
        @(negedge clk);
        addr = 6'd5; wr_data = 8'hC3; sel_n = 1'b1; drv_n = 1'b0; st_n = 1'b0;
        #1;
        check(!rd_oe && !flag_oe && rd_data == 0 && !flag, "R1 deselect",
              {rd_oe, flag_oe, flag}, 0);
        @(negedge clk);
        st_n = 1'b1; drv_n = 1'b1;
        read_expect(6'd5, 8'h3C, 1'b0, "R1 no store while deselected");
        // R4: selected, nothing requested
        @(negedge clk);
        sel_n = 1'b0; drv_n = 1'b1; st_n = 1'b1;
        #1;
        check(!rd_oe && !flag_oe, "R4 quiet", {rd_oe, flag_oe}, 0);
        sel_n = 1'b1;
        // R3: store with drive request also low
        @(negedge clk);
        addr = 6'd6; wr_data = 8'h96; sel_n = 1'b0; drv_n = 1'b0; st_n = 1'b0;
        #1;
        check(!rd_oe && !flag_oe, "R3 no drive during store", {rd_oe, flag_oe}, 0);
        @(negedge clk);
        st_n = 1'b1; sel_n = 1'b1; drv_n = 1'b1;
        read_expect(6'd6, 8'h96, 1'b0, "R3 stored with drive low");
    endtask

    task automatic t_store_end();
        // R5: byte changes each cycle; the last value sampled while active is kept
        @(negedge clk);
        addr = 6'd9; wr_data = 8'h11; sel_n = 1'b0; st_n = 1'b0;
        @(negedge clk); wr_data = 8'h22;
        @(negedge clk); wr_data = 8'h33;
        @(negedge clk); wr_data = 8'h44; st_n = 1'b1;
        @(negedge clk); sel_n = 1'b1;
        read_expect(6'd9, 8'h33, 1'b0, "R5 ended by store strobe");
        @(negedge clk);
        addr = 6'd10; wr_data = 8'h7E; sel_n = 1'b0; st_n = 1'b0;
        @(negedge clk); wr_data = 8'hE7; sel_n = 1'b1;
        @(negedge clk); st_n = 1'b1;
        read_expect(6'd10, 8'h7E, 1'b0, "R5 ended by select");
    endtask

    task automatic t_clean();
        logic [7:0] pats [4] = '{8'h00, 8'hFF, 8'hA5, 8'h5A};
        for (int i = 0; i < 4; i++) store(AW'(16 + i), pats[i], i[0], 1'b1);
        for (int i = 0; i < 4; i++) read_expect(AW'(16 + i), pats[i], 1'b0, "R2 R7 pattern");
        for (int k = 0; k < 8; k++) begin
            store(6'd24, 8'(1 << k), 1'b0, 1'b1);
            read_expect(6'd24, 8'(1 << k), 1'b0, "R7 walking one");
        end
    endtask

    task automatic t_single();
        for (int p = 0; p < 13; p++) begin
            store(6'd30, 8'hC6, 1'b0, 1'b1);
            flip(6'd30, p);
            read_expect(6'd30, 8'hC6, 1'b1, "R6 R11 single flip");
            read_expect(6'd30, 8'hC6, 1'b1, "R8 still flagged");
        end
        store(6'd30, 8'hC6, 1'b1, 1'b1);
        read_expect(6'd30, 8'hC6, 1'b0, "R8 restore clears");
        flip(6'd30, 13);
        flip(6'd30, 15);
        read_expect(6'd30, 8'hC6, 1'b0, "R11 out-of-range position");
    endtask

    task automatic t_double();
        store(6'd40, 8'hA5, 1'b0, 1'b1);
        flip(6'd40, data_bit_pos(0));
        flip(6'd40, data_bit_pos(1));
        read_expect(6'd40, 8'hA6, 1'b0, "R9 two data bits");
        store(6'd41, 8'h0F, 1'b0, 1'b1);
        flip(6'd41, data_bit_pos(7));
        flip(6'd41, 1);
        read_expect(6'd41, 8'h8F, 1'b0, "R9 data and check bit");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_modes();
        t_store_end();
        t_clean();
        t_single();
        t_double();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule